// File: doc/BRIEF.md
# Paravirtual Queue Configuration Register File

This block is the common-configuration register file of a paravirtual device that serves several request queues. A simple register bus gives an offset, an access size in bytes, little-endian write data and separate read and write strobes. The block decodes each access by size and offset. Global state covers a device status byte, a configuration generation counter and two 32-bit feature page selects. Per-queue state covers a ring size, a ready flag and three 64-bit ring base addresses (descriptor, available, used), reached through a queue-select register.

Device feature words enter on a feature input for the page the block presents on its page output. A driver feature write is forwarded as a one-cycle acknowledge pulse carrying the value and the current driver page. Per-queue state is exported on flat output vectors for the queue engine; queue `i` occupies bits `[i*64 +: 64]` of each address vector, `[i*16 +: 16]` of `q_size` and bit `i` of `q_ready`.

Top module: `pvq_cfg_regs`

## Requirements
- R1: After reset the status byte, both feature selects, the queue select, the generation counter and every queue's size, ready flag and addresses are zero.
- R2: A 1-byte write at 0x14 sets all 8 status bits, read back by a 1-byte read at 0x14. A 1-byte read at 0x15 returns the generation counter, which increments by one (modulo 256) on every cycle `cfg_change` is high; writes cannot change it.
- R3: 4-byte accesses at 0x00 (device page) and 0x08 (driver page) are read/write. `feat_page` shows the device page. A 4-byte read at 0x04 returns `feat_word`, with bit 0 forced to 1 when the device page equals 1.
- R4: A 4-byte write at 0x0C makes `ack_valid` high for exactly the next cycle, with `ack_bits` equal to the written value and `ack_page` equal to the driver page.
- R5: A 2-byte read at 0x12 returns NQ. The 2-byte register at 0x16 is the queue select (read/write). A 2-byte read at 0x1E returns the queue select.
- R6: A 2-byte access at 0x18 reads/writes the selected queue's size. A 2-byte write at 0x1C sets the ready flag when the value is exactly 1 and clears it for any other value. A read at 0x1C returns 1 or 0.
- R7: 4-byte writes at 0x20/0x24, 0x28/0x2C and 0x30/0x34 replace the low/high half of the selected queue's descriptor, available and used address. The other half is left unchanged.
- R8: An 8-byte write at 0x20, 0x28 or 0x30 replaces the whole address. Every 8-byte read returns zero.
- R9: When the queue select is at least NQ, per-queue reads return zero and per-queue writes change no queue and raise no error.
- R10: The 2-byte registers at 0x10 and 0x1A read as zero and ignore writes without error.
- R11: Accesses whose size is not 1, 2, 4 or 8 change no state, raise no error and read zero. Reads at unmapped offsets return zero.
- R12: A write at an unmapped offset or at a read-only one (0x15 byte; 0x12 or 0x1E word; 0x04 dword) makes `bus_err` high for the next cycle only and changes no state.
- R13: Read data appears on `bus_rdata` with `bus_rvalid` high in the cycle after the read strobe. Otherwise both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_off | input | 8 | Byte offset of the access |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data, little-endian, right-aligned |
| bus_rdata | output | 64 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| bus_err | output | 1 | One-cycle flag for a rejected write |
| feat_page | output | 32 | Device feature page currently selected |
| feat_word | input | 32 | Device feature word for `feat_page` |
| ack_valid | output | 1 | Driver feature acknowledge pulse |
| ack_page | output | 32 | Driver page of the acknowledge |
| ack_bits | output | 32 | Acknowledged feature bits |
| cfg_change | input | 1 | Configuration change event, bumps the generation |
| q_ready | output | NQ | Ready flag per queue |
| q_size | output | NQ*16 | Ring size per queue |
| q_desc | output | NQ*64 | Descriptor ring base per queue |
| q_avail | output | NQ*64 | Available ring base per queue |
| q_used | output | NQ*64 | Used ring base per queue |

## Verification
The properties assume a read and a write are never issued in the same cycle. Under that assumption every `bus_err` or `ack_valid` pulse can be traced to the write of the previous cycle, and every `bus_rvalid` to a read. They also assume `feat_word` only changes between accesses. The stimulus issues one access per task call with only one strobe high, and holds `feat_word` constant across each read. It walks the queue select both inside and past NQ, so the dropped-write and zero-read paths are exercised without breaking those assumptions.

// File: rtl/pvq_pkg.sv
package pvq_pkg;

    localparam int OFF_W  = 8;
    localparam int QSZ_W  = 16;
    localparam int ADR_W  = 64;

    // byte offsets of the register window
    localparam logic [OFF_W-1:0] OFF_DEV_SEL  = 8'h00;
    localparam logic [OFF_W-1:0] OFF_DEV_FEAT = 8'h04;
    localparam logic [OFF_W-1:0] OFF_DRV_SEL  = 8'h08;
    localparam logic [OFF_W-1:0] OFF_DRV_ACK  = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_CFG_VEC  = 8'h10;
    localparam logic [OFF_W-1:0] OFF_NUM_Q    = 8'h12;
    localparam logic [OFF_W-1:0] OFF_STATUS   = 8'h14;
    localparam logic [OFF_W-1:0] OFF_GEN      = 8'h15;
    localparam logic [OFF_W-1:0] OFF_QSEL     = 8'h16;
    localparam logic [OFF_W-1:0] OFF_QSIZE    = 8'h18;
    localparam logic [OFF_W-1:0] OFF_QVEC     = 8'h1A;
    localparam logic [OFF_W-1:0] OFF_QEN      = 8'h1C;
    localparam logic [OFF_W-1:0] OFF_QNOTIFY  = 8'h1E;
    localparam logic [OFF_W-1:0] OFF_DESC     = 8'h20;
    localparam logic [OFF_W-1:0] OFF_AVAIL    = 8'h28;
    localparam logic [OFF_W-1:0] OFF_USED     = 8'h30;

    typedef enum logic [2:0] {
        QOP_NONE,
        QOP_SIZE,
        QOP_READY,
        QOP_LO,
        QOP_HI,
        QOP_FULL
    } qop_e;

    typedef struct packed {
        logic [QSZ_W-1:0] size;
        logic             ready;
        logic [ADR_W-1:0] desc;
        logic [ADR_W-1:0] avail;
        logic [ADR_W-1:0] used;
    } qstate_t;

    typedef struct packed {
        logic [7:0]       status;
        logic [7:0]       gen;
        logic [31:0]      dev_sel;
        logic [31:0]      drv_sel;
        logic [15:0]      qsel;
        logic             ack_v;
        logic [31:0]      ack_page;
        logic [31:0]      ack_bits;
        logic             err;
        logic [63:0]      rdata;
        logic             rvalid;
    } glob_t;

endpackage

// File: rtl/pvq_queue_bank.sv
module pvq_queue_bank
    import pvq_pkg::*;
#(
    parameter int NQ = 4,
    localparam int QIDX_W = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  qop_e              op,
    input  logic [1:0]        ring_idx,
    input  logic [QIDX_W-1:0] qidx,
    input  logic              hit,
    input  logic [63:0]       wdata,
    output qstate_t           q_o [NQ]
);

    function automatic logic [ADR_W-1:0] merge_addr(
        input logic [ADR_W-1:0] old,
        input qop_e             kind,
        input logic [63:0]      wd
    );
        case (kind)
            QOP_LO:   merge_addr = {old[63:32], wd[31:0]};
            QOP_HI:   merge_addr = {wd[31:0], old[31:0]};
            QOP_FULL: merge_addr = wd;
            default:  merge_addr = old;
        endcase
    endfunction

    for (genvar i = 0; i < NQ; i++) begin : g_q
        qstate_t s_d, s_q;

        always_comb begin
            s_d = s_q;
            if (hit && (qidx == QIDX_W'(i))) begin
                case (op)
                    QOP_SIZE:  s_d.size  = wdata[QSZ_W-1:0];
                    QOP_READY: s_d.ready = (wdata[15:0] == 16'd1);
                    QOP_LO, QOP_HI, QOP_FULL: begin
                        case (ring_idx)
                            2'd0:    s_d.desc  = merge_addr(s_q.desc, op, wdata);
                            2'd1:    s_d.avail = merge_addr(s_q.avail, op, wdata);
                            2'd2:    s_d.used  = merge_addr(s_q.used, op, wdata);
                            default: ;
                        endcase
                    end
                    default: ;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign q_o[i] = s_q;
    end

endmodule

// File: rtl/pvq_read_mux.sv
module pvq_read_mux
    import pvq_pkg::*;
#(
    parameter int NQ = 4
) (
    input  logic [3:0]       size,
    input  logic [OFF_W-1:0] off,
    input  logic [7:0]       status,
    input  logic [7:0]       gen,
    input  logic [31:0]      dev_sel,
    input  logic [31:0]      drv_sel,
    input  logic [15:0]      qsel,
    input  logic [QSZ_W-1:0] sel_size,
    input  logic             sel_ready,
    input  logic             hit,
    input  logic [31:0]      feat_word,
    output logic [63:0]      rdata
);

    always_comb begin
        rdata = '0;
        case (size)
            4'd1: begin
                case (off)
                    OFF_STATUS: rdata[7:0] = status;
                    OFF_GEN:    rdata[7:0] = gen;
                    default:    ;
                endcase
            end
            4'd2: begin
                case (off)
                    OFF_NUM_Q:   rdata[15:0] = 16'(NQ);
                    OFF_QSEL:    rdata[15:0] = qsel;
                    OFF_QSIZE:   rdata[15:0] = hit ? sel_size : '0;
                    OFF_QEN:     rdata[0]    = hit & sel_ready;
                    OFF_QNOTIFY: rdata[15:0] = qsel;
                    default:     ;
                endcase
            end
            4'd4: begin
                case (off)
                    OFF_DEV_SEL:  rdata[31:0] = dev_sel;
                    OFF_DEV_FEAT: rdata[31:0] = feat_word | {31'd0, (dev_sel == 32'd1)};
                    OFF_DRV_SEL:  rdata[31:0] = drv_sel;
                    default:      ;
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pvq_cfg_regs.sv
module pvq_cfg_regs
    import pvq_pkg::*;
#(
    parameter int NQ = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [7:0]       bus_off,
    input  logic [3:0]       bus_size,
    input  logic [63:0]      bus_wdata,
    output logic [63:0]      bus_rdata,
    output logic             bus_rvalid,
    output logic             bus_err,
    output logic [31:0]      feat_page,
    input  logic [31:0]      feat_word,
    output logic             ack_valid,
    output logic [31:0]      ack_page,
    output logic [31:0]      ack_bits,
    input  logic             cfg_change,
    output logic [NQ-1:0]    q_ready,
    output logic [NQ*16-1:0] q_size,
    output logic [NQ*64-1:0] q_desc,
    output logic [NQ*64-1:0] q_avail,
    output logic [NQ*64-1:0] q_used
);

    localparam int QIDX_W = (NQ > 1) ? $clog2(NQ) : 1;

    glob_t g_d, g_q;
    qop_e  qop;
    logic [1:0]        ring_idx;
    logic              hit;
    logic [QIDX_W-1:0] qidx;
    qstate_t           q_arr [NQ];
    qstate_t           sel_st;
    logic [63:0]       rd_val;
    logic [7:0]        gen_now;
    logic [15:0]       qsel_now;

    assign hit  = (32'(g_q.qsel) < NQ);
    assign qidx = g_q.qsel[QIDX_W-1:0];
    assign sel_st = hit ? q_arr[qidx] : '0;

    pvq_queue_bank #(.NQ(NQ)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (qop),
        .ring_idx (ring_idx),
        .qidx     (qidx),
        .hit      (hit),
        .wdata    (bus_wdata),
        .q_o      (q_arr)
    );

    pvq_read_mux #(.NQ(NQ)) u_rmux (
        .size      (bus_size),
        .off       (bus_off),
        .status    (g_q.status),
        .gen       (g_q.gen),
        .dev_sel   (g_q.dev_sel),
        .drv_sel   (g_q.drv_sel),
        .qsel      (g_q.qsel),
        .sel_size  (sel_st.size),
        .sel_ready (sel_st.ready),
        .hit       (hit),
        .feat_word (feat_word),
        .rdata     (rd_val)
    );

    // write decode and next-state
    always_comb begin
        g_d        = g_q;
        g_d.ack_v  = 1'b0;
        g_d.err    = 1'b0;
        g_d.rvalid = bus_rd;
        g_d.rdata  = bus_rd ? rd_val : '0;
        qop        = QOP_NONE;
        ring_idx   = 2'd0;

        if (cfg_change) g_d.gen = g_q.gen + 8'd1;

        if (bus_wr) begin
            case (bus_size)
                4'd1: begin
                    case (bus_off)
                        OFF_STATUS: g_d.status = bus_wdata[7:0];
                        default:    g_d.err = 1'b1;
                    endcase
                end
                4'd2: begin
                    case (bus_off)
                        OFF_QSEL:    g_d.qsel = bus_wdata[15:0];
                        OFF_QSIZE:   qop = QOP_SIZE;
                        OFF_QEN:     qop = QOP_READY;
                        OFF_CFG_VEC,
                        OFF_QVEC:    ;
                        default:     g_d.err = 1'b1;
                    endcase
                end
                4'd4: begin
                    case (bus_off)
                        OFF_DEV_SEL: g_d.dev_sel = bus_wdata[31:0];
                        OFF_DRV_SEL: g_d.drv_sel = bus_wdata[31:0];
                        OFF_DRV_ACK: begin
                            g_d.ack_v    = 1'b1;
                            g_d.ack_page = g_q.drv_sel;
                            g_d.ack_bits = bus_wdata[31:0];
                        end
                        8'h20, 8'h24, 8'h28, 8'h2C, 8'h30, 8'h34: begin
                            qop      = bus_off[2] ? QOP_HI : QOP_LO;
                            ring_idx = 2'(bus_off[5:3] - 3'd4);
                        end
                        default: g_d.err = 1'b1;
                    endcase
                end
                4'd8: begin
                    case (bus_off)
                        OFF_DESC, OFF_AVAIL, OFF_USED: begin
                            qop      = QOP_FULL;
                            ring_idx = 2'(bus_off[5:3] - 3'd4);
                        end
                        default: g_d.err = 1'b1;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign bus_rdata  = g_q.rdata;
    assign bus_rvalid = g_q.rvalid;
    assign bus_err    = g_q.err;
    assign feat_page  = g_q.dev_sel;
    assign ack_valid  = g_q.ack_v;
    assign ack_page   = g_q.ack_page;
    assign ack_bits   = g_q.ack_bits;
    assign gen_now    = g_q.gen;
    assign qsel_now   = g_q.qsel;

    for (genvar i = 0; i < NQ; i++) begin : g_out
        assign q_ready[i]          = q_arr[i].ready;
        assign q_size[i*16 +: 16]  = q_arr[i].size;
        assign q_desc[i*64 +: 64]  = q_arr[i].desc;
        assign q_avail[i*64 +: 64] = q_arr[i].avail;
        assign q_used[i*64 +: 64]  = q_arr[i].used;
    end

endmodule

// File: rtl/pvq_cfg_regs_chk.sv
module pvq_cfg_regs_chk #(
    parameter int NQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_rd,
    input logic             bus_wr,
    input logic [7:0]       bus_off,
    input logic [3:0]       bus_size,
    input logic             bus_rvalid,
    input logic             bus_err,
    input logic             ack_valid,
    input logic             cfg_change,
    input logic [7:0]       gen_now,
    input logic [15:0]      qsel_now,
    input logic [NQ-1:0]    q_ready,
    input logic [NQ*64-1:0] q_desc,
    input logic [NQ*64-1:0] q_used
);

    logic size_ok;
    assign size_ok = (bus_size == 4'd1) || (bus_size == 4'd2) ||
                     (bus_size == 4'd4) || (bus_size == 4'd8);

    assert_rvalid_follow_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);

    assert_rvalid_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_rd));

    assert_ack_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(bus_wr && bus_size == 4'd4 && bus_off == 8'h0C));

    assert_err_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(bus_wr && size_ok));

    assert_bad_size_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !size_ok) |=> (!bus_err && $stable(q_ready) && $stable(q_desc)));

    assert_gen_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> (gen_now == $past(gen_now) + 8'd1));

    assert_gen_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_change |=> $stable(gen_now));

    assert_drop_out_of_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && 32'(qsel_now) >= NQ) |=> ($stable(q_ready) && $stable(q_desc) && $stable(q_used)));

endmodule

bind pvq_cfg_regs pvq_cfg_regs_chk #(.NQ(NQ)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_off    (bus_off),
    .bus_size   (bus_size),
    .bus_rvalid (bus_rvalid),
    .bus_err    (bus_err),
    .ack_valid  (ack_valid),
    .cfg_change (cfg_change),
    .gen_now    (gen_now),
    .qsel_now   (qsel_now),
    .q_ready    (q_ready),
    .q_desc     (q_desc),
    .q_used     (q_used)
);

// File: tb/pvq_cfg_regs_test.sv
`timescale 1ns/1ps
module pvq_cfg_regs_test;

    localparam int NQ = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]       bus_off = '0;
    logic [3:0]       bus_size = '0;
    logic [63:0]      bus_wdata = '0;
    logic [63:0]      bus_rdata;
    logic             bus_rvalid, bus_err;
    logic [31:0]      feat_page;
    logic [31:0]      feat_word = 32'h1234_5670;
    logic             ack_valid;
    logic [31:0]      ack_page, ack_bits;
    logic             cfg_change = 1'b0;
    logic [NQ-1:0]    q_ready;
    logic [NQ*16-1:0] q_size;
    logic [NQ*64-1:0] q_desc, q_avail, q_used;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pvq_cfg_regs #(.NQ(NQ)) uut (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] off, input logic [3:0] sz, input logic [63:0] d,
                      output logic e, output logic av);
        @(negedge clk);
        bus_wr = 1'b1; bus_off = off; bus_size = sz; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        e  = bus_err;
        av = ack_valid;
    endtask

    task automatic rd(input logic [7:0] off, input logic [3:0] sz,
                      output logic [63:0] v, output logic vv);
        @(negedge clk);
        bus_rd = 1'b1; bus_off = off; bus_size = sz;
        @(negedge clk);
        bus_rd = 1'b0;
        v  = bus_rdata;
        vv = bus_rvalid;
    endtask

    // {is_wr, req, size, offset, data, expected}; for writes expected is the error flag
    localparam int NV = 30;
    localparam logic [144:0] VEC [NV] = '{
        {1'b1, 4'd2,  4'd1, 8'h14, 64'h55,        64'h0},        // R2 status write
        {1'b0, 4'd2,  4'd1, 8'h14, 64'h0,         64'h55},       // R2
        {1'b1, 4'd12, 4'd1, 8'h15, 64'hAA,        64'h1},        // R12 gen read-only
        {1'b0, 4'd2,  4'd1, 8'h15, 64'h0,         64'h0},        // R2 gen unchanged
        {1'b1, 4'd3,  4'd4, 8'h00, 64'h04030201,  64'h0},        // R3
        {1'b0, 4'd3,  4'd4, 8'h00, 64'h0,         64'h04030201}, // R3
        {1'b1, 4'd3,  4'd4, 8'h08, 64'h0A0B0C0D,  64'h0},        // R3
        {1'b0, 4'd3,  4'd4, 8'h08, 64'h0,         64'h0A0B0C0D}, // R3
        {1'b1, 4'd5,  4'd2, 8'h16, 64'h2,         64'h0},        // R5 select queue 2
        {1'b0, 4'd5,  4'd2, 8'h16, 64'h0,         64'h2},        // R5
        {1'b0, 4'd5,  4'd2, 8'h1E, 64'h0,         64'h2},        // R5 notify offset
        {1'b0, 4'd5,  4'd2, 8'h12, 64'h0,         64'h4},        // R5 queue count
        {1'b1, 4'd6,  4'd2, 8'h18, 64'h0100,      64'h0},        // R6
        {1'b0, 4'd6,  4'd2, 8'h18, 64'h0,         64'h0100},     // R6
        {1'b1, 4'd6,  4'd2, 8'h1C, 64'h1,         64'h0},        // R6 enable
        {1'b0, 4'd6,  4'd2, 8'h1C, 64'h0,         64'h1},        // R6
        {1'b1, 4'd6,  4'd2, 8'h1C, 64'h2,         64'h0},        // R6 value 2 clears
        {1'b0, 4'd6,  4'd2, 8'h1C, 64'h0,         64'h0},        // R6
        {1'b1, 4'd10, 4'd2, 8'h10, 64'hFFFF,      64'h0},        // R10
        {1'b0, 4'd10, 4'd2, 8'h10, 64'h0,         64'h0},        // R10
        {1'b1, 4'd10, 4'd2, 8'h1A, 64'hFFFF,      64'h0},        // R10
        {1'b0, 4'd10, 4'd2, 8'h1A, 64'h0,         64'h0},        // R10
        {1'b1, 4'd12, 4'd2, 8'h12, 64'h9,         64'h1},        // R12 count read-only
        {1'b0, 4'd12, 4'd2, 8'h12, 64'h0,         64'h4},        // R12 unchanged
        {1'b1, 4'd12, 4'd4, 8'h04, 64'hFFFFFFFF,  64'h1},        // R12 feature word read-only
        {1'b0, 4'd8,  4'd8, 8'h20, 64'h0,         64'h0},        // R8 8-byte read zero
        {1'b1, 4'd11, 4'd3, 8'h14, 64'hFF,        64'h0},        // R11 odd size ignored
        {1'b0, 4'd11, 4'd1, 8'h14, 64'h0,         64'h55},       // R11 status kept
        {1'b0, 4'd11, 4'd3, 8'h14, 64'h0,         64'h0},        // R11 odd size reads zero
        {1'b1, 4'd12, 4'd1, 8'h40, 64'h1,         64'h1}         // R12 unmapped write
    };

    initial begin : wdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] v;
        logic vv, e, av;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h14, 4'd1, v, vv); check("R1 status", v, 64'h0);
        rd(8'h00, 4'd4, v, vv); check("R1 dev sel", v, 64'h0);
        rd(8'h16, 4'd2, v, vv); check("R1 qsel", v, 64'h0);
        check("R1 q_ready", 64'(q_ready), 64'h0);
        check("R1 q_desc", q_desc[63:0], 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic [144:0] t;
            string tag;
            t = VEC[i];
            tag = $sformatf("R%0d vec%0d", t[143:140], i);
            if (t[144]) begin
                wr(t[135:128], t[139:136], t[127:64], e, av);
                check(tag, 64'(e), t[63:0]);
            end else begin
                rd(t[135:128], t[139:136], v, vv);
                check(tag, v, t[63:0]);
            end
        end
        rd(8'h40, 4'd1, v, vv); check("R11 unmapped read", v, 64'h0);

        // R13 read timing
        rd(8'h14, 4'd1, v, vv); check("R13 rvalid", 64'(vv), 64'h1);
        @(negedge clk);
        check("R13 rvalid idle", 64'(bus_rvalid), 64'h0);
        check("R13 rdata idle", bus_rdata, 64'h0);

        // R3 page-1 bit force
        wr(8'h00, 4'd4, 64'h1, e, av);
        check("R3 feat_page", 64'(feat_page), 64'h1);
        rd(8'h04, 4'd4, v, vv); check("R3 page1 bit0", v, 64'h12345671);
        wr(8'h00, 4'd4, 64'h2, e, av);
        rd(8'h04, 4'd4, v, vv); check("R3 page2", v, 64'h12345670);

        // R4 acknowledge pulse
        wr(8'h0C, 4'd4, 64'h5555AAAA, e, av);
        check("R4 ack valid", 64'(av), 64'h1);
        check("R4 ack bits", 64'(ack_bits), 64'h5555AAAA);
        check("R4 ack page", 64'(ack_page), 64'h0A0B0C0D);
        @(negedge clk);
        check("R4 ack one cycle", 64'(ack_valid), 64'h0);

        // R7 halves on queue 2
        wr(8'h20, 4'd4, 64'h11111111, e, av);
        wr(8'h24, 4'd4, 64'h22222222, e, av);
        check("R7 desc", q_desc[128 +: 64], 64'h22222222_11111111);
        wr(8'h20, 4'd4, 64'h33333333, e, av);
        check("R7 desc lo only", q_desc[128 +: 64], 64'h22222222_33333333);
        wr(8'h34, 4'd4, 64'h44444444, e, av);
        check("R7 used hi", q_used[128 +: 64], 64'h44444444_00000000);
        check("R7 queue0 untouched", q_desc[63:0], 64'h0);

        // R8 full write
        wr(8'h28, 4'd8, 64'hAABBCCDD_EEFF0011, e, av);
        check("R8 avail full", q_avail[128 +: 64], 64'hAABBCCDD_EEFF0011);
        check("R8 no error", 64'(e), 64'h0);

        // R9 out-of-range queue select
        wr(8'h16, 4'd2, 64'h4, e, av);
        rd(8'h18, 4'd2, v, vv); check("R9 size read", v, 64'h0);
        rd(8'h1C, 4'd2, v, vv); check("R9 ready read", v, 64'h0);
        wr(8'h18, 4'd2, 64'h77, e, av); check("R9 no error", 64'(e), 64'h0);
        wr(8'h30, 4'd8, 64'hDEAD, e, av);
        check("R9 used dropped", q_used[128 +: 64], 64'h44444444_00000000);
        check("R9 sizes dropped", 64'(q_size), 64'h0000_0100_0000_0000);
        wr(8'h16, 4'd2, 64'h2, e, av);
        rd(8'h18, 4'd2, v, vv); check("R9 q2 kept", v, 64'h0100);

        // R2 generation counter
        @(negedge clk); cfg_change = 1'b1;
        repeat (3) @(negedge clk);
        cfg_change = 1'b0;
        rd(8'h15, 4'd1, v, vv); check("R2 gen count", v, 64'h3);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(8'h14, 4'd1, v, vv); check("R1 status after reset", v, 64'h0);
        check("R1 desc after reset", q_desc[128 +: 64], 64'h0);
        check("R1 size after reset", 64'(q_size), 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule